// File: doc/BRIEF.md
# Shared interrupt router

This block takes a small set of interrupt lines shared by all cores of a cluster and steers each one to the interrupt controller of exactly one core. Each shared interrupt has three settings of its own: a destination core mask, a distribution policy and a mask bit. The whole block also has a single enable that is off out of reset. All settings are written through one command port. Each command carries an opcode, an interrupt index and a data word, and takes effect at the clock edge on which `cmd_valid` is high.

There are two distribution policies. Fixed delivery always sends the interrupt to the lowest-numbered core in its destination mask. Round-robin delivery keeps a pointer for each interrupt and hands each new assertion to the next core in the mask, so that load spreads over the cores. All inputs are level sensitive. Once an assertion has been given to a core, it stays with that core until the input falls.

The output vector holds one line per shared interrupt per core. Line `c*NUM_IRQ + i` carries shared interrupt `i` to core `c`, where it feeds that core's interrupt input number 24+i. Core inputs 16 to 23 stay private to each core and are not driven here. `NUM_CORE` may be at most 32.

Top module: `shared_irq_router`

## Requirements
- R1: After reset every output is low, every shared interrupt is masked, every destination mask is zero, every policy is fixed delivery, and the global enable is off.
- R2: Opcode 0 writes `cmd_data[NUM_CORE-1:0]` as the destination mask of interrupt `cmd_idx`, where bit c selects core c. The new mask is used for the next delivery decision of that interrupt.
- R3: Opcode 1 sets the policy of interrupt `cmd_idx` from `cmd_data[1:0]`: 2'b01 selects round-robin and every other value selects fixed delivery. All other data bits have no effect.
- R4: Opcode 2 with `cmd_data[0]`=1 masks interrupt `cmd_idx`, and with `cmd_data[0]`=0 unmasks it. From the edge that accepts the mask command, all output lines of a masked interrupt are low. An assertion held under the mask reappears on its old core after unmask.
- R5: No output line rises before opcode 3 (enable) has been accepted. The data and index of the enable command are ignored.
- R6: Under fixed delivery, a new assertion goes to the lowest-numbered core whose bit is set in the destination mask.
- R7: Under round-robin, a new assertion goes to the first set mask bit at or above the interrupt's pointer, wrapping past the top core. The pointer starts at 0. When the input falls, the pointer moves to one past the core that was served, wrapping to 0.
- R8: The output line rises on the first clock edge at which the input is high, the block is enabled, the interrupt is unmasked and the mask is non-zero. It stays on the same core while the input stays high, even if the mask or policy is rewritten. It falls on the first edge at which the input is low.
- R9: An interrupt whose destination mask is all zero is never delivered.
- R10: Output bit `c*NUM_IRQ+i` is interrupt i on core c. At most one core carries a given interrupt at any time, and different interrupts may be delivered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 destination, 1 policy, 2 mask, 3 enable |
| cmd_idx | input | IDX_W | Shared interrupt index |
| cmd_data | input | DATA_W | Command data word |
| irq_in | input | NUM_IRQ | Level-sensitive shared interrupt inputs |
| core_irq | output | NUM_CORE*NUM_IRQ | Per-core lines, bit c*NUM_IRQ+i is interrupt i on core c |

## Verification
Configuration writes and interrupt traffic share the same clock edge. The risky cases are a destination rewrite, a policy change, or a mask or unmask that lands while the interrupt it touches is held high, or on the very edge where the input rises. The bench issues such commands with the input high and checks that the held core is kept, that the mask gates the line at once, and that a newly written mask is used only at the next rise. It also raises two interrupts on one edge and checks that each lands on its own core without disturbing the other.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int MAX_CORES = 32;

  typedef enum logic [1:0] {
    OP_SET_DEST = 2'd0,
    OP_SET_MODE = 2'd1,
    OP_SET_MASK = 2'd2,
    OP_ENABLE   = 2'd3
  } sirq_op_e;

  // policy field value that selects round-robin (R3)
  localparam logic [1:0] POLICY_RR = 2'b01;

  // lowest set bit among the first n bits of m, 0 when none
  function automatic int lowest_set(input logic [MAX_CORES-1:0] m, input int n);
    int pick;
    pick = 0;
    for (int k = MAX_CORES - 1; k >= 0; k--) begin
      if (k < n && m[k]) pick = k;
    end
    return pick;
  endfunction

  // first set bit at or above start, wrapping at n
  function automatic int rr_pick(input logic [MAX_CORES-1:0] m, input int start, input int n);
    int   pick;
    logic found;
    pick  = 0;
    found = 1'b0;
    for (int k = 0; k < MAX_CORES; k++) begin
      int j;
      j = start + k;
      if (j >= n) j = j - n;
      if (k < n && !found && j >= 0 && j < MAX_CORES) begin
        if (m[j]) begin
          pick  = j;
          found = 1'b1;
        end
      end
    end
    return pick;
  endfunction

  // core after c, wrapping at n
  function automatic int wrap_next(input int c, input int n);
    return (c + 1 >= n) ? 0 : c + 1;
  endfunction

endpackage

// File: rtl/sirq_cfg_regs.sv
module sirq_cfg_regs
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [1:0]                         cmd_op,
  input  logic [IDX_W-1:0]                   cmd_idx,
  input  logic [DATA_W-1:0]                  cmd_data,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_q,
  output logic [NUM_IRQ-1:0]                 rr_q,
  output logic [NUM_IRQ-1:0]                 mask_q,
  output logic                               en_q
);

  sirq_op_e op;
  logic     unused_data;

  assign op          = sirq_op_e'(cmd_op);
  assign unused_data = ^cmd_data;

  // global enable: set once, held until reset (R5)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (cmd_valid && op == OP_ENABLE) begin
      en_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic                hit;
    logic [NUM_CORE-1:0] dest_r;
    logic                rr_r;
    logic                mask_r;

    assign hit = cmd_valid && (cmd_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dest_r <= '0;
        rr_r   <= 1'b0;
        mask_r <= 1'b1;
      end else if (hit) begin
        case (op)
          OP_SET_DEST: dest_r <= cmd_data[NUM_CORE-1:0];
          OP_SET_MODE: rr_r   <= (cmd_data[1:0] == POLICY_RR);
          OP_SET_MASK: mask_r <= cmd_data[0];
          default: ;
        endcase
      end
    end

    assign dest_q[i] = dest_r;
    assign rr_q[i]   = rr_r;
    assign mask_q[i] = mask_r;
  end

endmodule

// File: rtl/sirq_channel.sv
module sirq_channel
  import sirq_pkg::*;
#(
  parameter int NUM_CORE = 4,
  parameter int CORE_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_level,
  input  logic [NUM_CORE-1:0] dest,
  input  logic                rr_mode,
  input  logic                masked,
  input  logic                enabled,
  output logic                active,
  output logic [CORE_W-1:0]   target,
  output logic                grant_evt,
  output logic                release_evt,
  output logic [NUM_CORE-1:0] lines
);

  logic              act_q;
  logic [CORE_W-1:0] tgt_q;
  logic [CORE_W-1:0] ptr_q;
  logic              deliverable;
  int                pick;

  assign deliverable = irq_level && enabled && !masked && (dest != '0);
  assign grant_evt   = !act_q && deliverable;
  assign release_evt = act_q && !irq_level;

  always_comb begin
    if (rr_mode) pick = rr_pick(MAX_CORES'(dest), int'(ptr_q), NUM_CORE);
    else         pick = lowest_set(MAX_CORES'(dest), NUM_CORE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      tgt_q <= '0;
      ptr_q <= '0;
    end else if (grant_evt) begin
      act_q <= 1'b1;
      tgt_q <= CORE_W'(pick);
    end else if (release_evt) begin
      act_q <= 1'b0;
      if (rr_mode) ptr_q <= CORE_W'(wrap_next(int'(tgt_q), NUM_CORE));
    end
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_line
    assign lines[c] = act_q && (tgt_q == CORE_W'(c)) && !masked && enabled;
  end

  assign active = act_q;
  assign target = tgt_q;

endmodule

// File: rtl/sirq_fanout.sv
module sirq_fanout #(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4
) (
  input  logic [NUM_IRQ-1:0][NUM_CORE-1:0] lines,
  output logic [NUM_CORE*NUM_IRQ-1:0]      core_irq
);

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign core_irq[c*NUM_IRQ + i] = lines[i][c];
    end
  end

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
  import sirq_pkg::*;
#(
  parameter int  NUM_IRQ  = 4,
  parameter int  NUM_CORE = 4,
  parameter int  DATA_W   = 32,
  localparam int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int CORE_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [IDX_W-1:0]             cmd_idx,
  input  logic [DATA_W-1:0]            cmd_data,
  input  logic [NUM_IRQ-1:0]           irq_in,
  output logic [NUM_CORE*NUM_IRQ-1:0]  core_irq
);

  logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest_q;
  logic [NUM_IRQ-1:0]               rr_q;
  logic [NUM_IRQ-1:0]               mask_q;
  logic                             en_q;

  logic [NUM_IRQ-1:0]               act_w;
  logic [NUM_IRQ-1:0][CORE_W-1:0]   tgt_w;
  logic [NUM_IRQ-1:0]               grant_evt;
  logic [NUM_IRQ-1:0]               release_evt;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] lines_w;

  sirq_cfg_regs #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_CORE (NUM_CORE),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .dest_q    (dest_q),
    .rr_q      (rr_q),
    .mask_q    (mask_q),
    .en_q      (en_q)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chan
    sirq_channel #(
      .NUM_CORE (NUM_CORE),
      .CORE_W   (CORE_W)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_level   (irq_in[i]),
      .dest        (dest_q[i]),
      .rr_mode     (rr_q[i]),
      .masked      (mask_q[i]),
      .enabled     (en_q),
      .active      (act_w[i]),
      .target      (tgt_w[i]),
      .grant_evt   (grant_evt[i]),
      .release_evt (release_evt[i]),
      .lines       (lines_w[i])
    );
  end

  sirq_fanout #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_CORE (NUM_CORE)
  ) u_fanout (
    .lines    (lines_w),
    .core_irq (core_irq)
  );

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_CORE = 4,
  parameter int CORE_W   = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cmd_valid,
  input logic [NUM_IRQ-1:0]                 irq_in,
  input logic [NUM_CORE*NUM_IRQ-1:0]        core_irq,
  input logic                               en_q,
  input logic [NUM_IRQ-1:0]                 mask_q,
  input logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_q,
  input logic [NUM_IRQ-1:0]                 act_w,
  input logic [NUM_IRQ-1:0][CORE_W-1:0]     tgt_w,
  input logic [NUM_IRQ-1:0]                 grant_evt,
  input logic [NUM_IRQ-1:0]                 release_evt
);

  a_r5_quiet_until_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> core_irq == '0);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [NUM_CORE-1:0] col;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_col
      assign col[c] = core_irq[c*NUM_IRQ + i];
    end

    a_r10_single_core: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    a_r4_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[i] |-> col == '0);

    a_r8_low_input_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[i] |=> col == '0);

    a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      release_evt[i] |=> !act_w[i]);

    a_r8_hold_core: assert property (@(posedge clk) disable iff (!rst_n)
      (col != '0 && irq_in[i] && !cmd_valid) |=> col == $past(col));

    a_r9_zero_dest_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_q[i] == '0 && !act_w[i]) |=> !act_w[i]);

    a_r7_grant_in_dest: assert property (@(posedge clk) disable iff (!rst_n)
      grant_evt[i] |=> ((($past(dest_q[i]) >> tgt_w[i]) & NUM_CORE'(1)) != '0));
  end

endmodule

bind shared_irq_router sirq_checker #(
  .NUM_IRQ  (NUM_IRQ),
  .NUM_CORE (NUM_CORE),
  .CORE_W   (CORE_W)
) u_sirq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .irq_in      (irq_in),
  .core_irq    (core_irq),
  .en_q        (en_q),
  .mask_q      (mask_q),
  .dest_q      (dest_q),
  .act_w       (act_w),
  .tgt_w       (tgt_w),
  .grant_evt   (grant_evt),
  .release_evt (release_evt)
);

// File: tb/test_shared_irq_router.sv
module test_shared_irq_router;
  import sirq_pkg::*;

  localparam int NI = 4;
  localparam int NC = 4;

  logic        clk       = 1'b0;
  logic        rst_n     = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op    = 2'd0;
  logic [1:0]  cmd_idx   = 2'd0;
  logic [31:0] cmd_data  = 32'd0;
  logic [3:0]  irq_in    = 4'd0;
  logic [15:0] core_irq;

  always #5 clk = ~clk;

  shared_irq_router #(.NUM_IRQ(NI), .NUM_CORE(NC)) i_shared_irq_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .irq_in    (irq_in),
    .core_irq  (core_irq)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bit for interrupt i on core c (R10)
  function automatic logic [15:0] b(input int c, input int i);
    return 16'(1) << (c * NI + i);
  endfunction

  task automatic check(input logic [15:0] got, input logic [15:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: core_irq=%h expected %h", tag, got, want);
    end
  endtask

  // driver: one cycle of stimulus plus the outputs expected after the next edge
  task automatic step(input logic v, input logic [1:0] op, input int idx,
                      input logic [31:0] data, input logic [3:0] lvl,
                      input logic [15:0] e, input string t);
    @(negedge clk);
    cmd_valid = v;
    cmd_op    = op;
    cmd_idx   = 2'(idx);
    cmd_data  = data;
    irq_in    = lvl;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input logic [3:0] lvl, input logic [15:0] e, input string t);
    step(1'b0, 2'd0, 0, 32'd0, lvl, e, t);
  endtask

  // monitor: compares after each edge, away from it
  always @(posedge clk) begin
    logic [15:0] e;
    string       t;
    #3;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(core_irq, e, t);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(core_irq, 16'h0, "R1 outputs low in reset");
    rst_n = 1'b1;

    idle(4'b0000, 16'h0, "R1 idle after reset");
    step(1'b1, OP_SET_DEST, 0, 32'h4, 4'b0001, 16'h0, "R5 masked and disabled");
    step(1'b1, OP_SET_MASK, 0, 32'h0, 4'b0001, 16'h0, "R5 unmask before enable");
    idle(4'b0001, 16'h0, "R5 unmasked but not enabled");
    step(1'b1, OP_ENABLE, 3, 32'h0, 4'b0001, 16'h0, "R5 enable edge");
    idle(4'b0001, b(2, 0), "R6 fixed to single core 2");
    step(1'b1, OP_SET_DEST, 0, 32'h1, 4'b0001, b(2, 0), "R8 held across dest rewrite");
    idle(4'b0000, 16'h0, "R8 falls with input");
    idle(4'b0001, b(0, 0), "R2 new mask used at next rise");
    step(1'b1, OP_SET_MASK, 0, 32'h1, 4'b0001, 16'h0, "R4 mask gates line");
    step(1'b1, OP_SET_MASK, 0, 32'h0, 4'b0001, b(0, 0), "R4 unmask restores held core");
    idle(4'b0000, 16'h0, "R8 release");

    step(1'b1, OP_SET_DEST, 1, 32'hB, 4'b0000, 16'h0, "R2 write mask 1011");
    step(1'b1, OP_SET_MODE, 1, 32'h11, 4'b0000, 16'h0, "R3 round-robin with level bit");
    step(1'b1, OP_SET_MASK, 1, 32'h0, 4'b0000, 16'h0, "R4 unmask irq1");
    idle(4'b0010, b(0, 1), "R7 first grant core 0");
    idle(4'b0000, 16'h0, "R7 release");
    idle(4'b0010, b(1, 1), "R7 second grant core 1");
    idle(4'b0000, 16'h0, "R7 release");
    idle(4'b0010, b(3, 1), "R7 skips unset core 2");
    idle(4'b0000, 16'h0, "R7 release");
    idle(4'b0010, b(0, 1), "R7 wraps to core 0");
    idle(4'b0000, 16'h0, "R7 release");
    idle(4'b0011, b(0, 0) | b(1, 1), "R10 two interrupts same edge");

    step(1'b1, OP_SET_MASK, 2, 32'h0, 4'b0100, 16'h0, "R9 zero mask after unmask");
    idle(4'b0100, 16'h0, "R9 zero mask never delivered");
    step(1'b1, OP_SET_DEST, 2, 32'h2, 4'b0100, 16'h0, "R9 mask written same edge");
    idle(4'b0100, b(1, 2), "R2 delivered after mask write");

    step(1'b1, OP_SET_MODE, 3, 32'hFFFF_FFFC, 4'b0000, 16'h0, "R3 reserved bits set");
    step(1'b1, OP_SET_DEST, 3, 32'h6, 4'b0000, 16'h0, "R2 write mask 0110");
    step(1'b1, OP_SET_MASK, 3, 32'h0, 4'b0000, 16'h0, "R4 unmask irq3");
    idle(4'b1000, b(1, 3), "R3 fixed lowest core 1");
    idle(4'b0000, 16'h0, "R8 release");
    idle(4'b1000, b(1, 3), "R3 reserved bits no round-robin");
    step(1'b1, OP_SET_MODE, 3, 32'h2, 4'b1000, b(1, 3), "R8 held across policy write");
    idle(4'b0000, 16'h0, "R8 release");
    idle(4'b1000, b(1, 3), "R6 policy 10 is fixed");

    @(negedge clk);
    cmd_valid = 1'b0;
    irq_in    = 4'b0000;
    repeat (3) @(posedge clk);
    #4;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule